// File: doc/BRIEF.md
# Cache prefetch request queue

This block sits beside a cache. It collects hardware prefetch candidates and hands them one at a time to the cache's memory request port. Demand misses come in on one channel. Candidate addresses, each with a delay, come in on a second channel from an external address generator. A candidate's ready time is the time of the latest accepted miss plus the candidate's delay. Candidates for one miss arrive in nondecreasing delay order, so the queue stays sorted by ready time from head to tail.

The queue compares whole cache blocks, never byte addresses. A candidate is dropped when any of these is true:
- its block is already held in the queue;
- its block is already outstanding in the miss queue;
- check-on-push mode is set and the block already hits in the cache.

When a miss is accepted, it removes any queued entry for the same block. With serial squash enabled, it also discards every entry whose ready time is at or after the miss time. When the queue is full, a new entry pushes out the oldest one. When check-on-push mode is clear, a head entry that hits in the cache is thrown away at issue time. Six event counters report what happened to the candidates.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty. `pf_valid_o` and `pf_req_o` are 0, every counter reads 0, and `cand_ready_o` is 1 while no miss is offered.
- R2: Block address = physical address with the low log2(BLK_BYTES) bits cleared (bits [5:0] for 64-byte blocks). Every queue match compares block addresses only.
- R3: A miss with `miss_uncacheable_i` high is ignored. A miss with `miss_ifetch_i` high is ignored while `cfg_data_only_i` is 1. An ignored miss removes nothing, squashes nothing and leaves the base time unchanged.
- R4: An accepted miss removes the queued entry with the same block, if there is one, and adds one to `cnt_miss_removed_o`.
- R5: With `cfg_serial_squash_i` at 1, an accepted miss discards every remaining entry whose ready time is >= `miss_time_i`, and adds the number discarded to `cnt_squashed_o`. With the bit at 0, nothing is squashed.
- R6: Ready time = last accepted miss time + `cand_delay_i`. The head is offered on `pf_valid_o` only once its ready time <= `now_i`.
- R7: A candidate is dropped if `cand_mq_hit_i` is high. It is dropped if `cfg_check_on_push_i` is 1 and `cand_tag_hit_i` is high. It is dropped if its block is already queued; only this last case adds one to `cnt_buf_hit_o`. The checks apply in that order.
- R8: Every candidate taken on the `cand_valid_i`/`cand_ready_o` handshake adds one to `cnt_identified_o`, before any filtering.
- R9: Inserting into a full queue drops the head entry and adds one to `cnt_evicted_o`. The new entry goes in at the tail.
- R10: `pf_valid_o` and `pf_ready_i` both high issues the head in FIFO order and adds one to `cnt_issued_o`. With `cfg_check_on_push_i` at 0, a ready head whose `head_tag_hit_i` is high is discarded without being issued.
- R11: `pf_req_o` rises on every insert and `pf_req_time_o` then carries that entry's ready time. `pf_req_o` falls when the queue empties, whether by issue, discard, miss removal or squash.
- R12: While `miss_valid_i` is high, `cand_ready_o` is 0, so no candidate is taken in that cycle.
- R13: Fullness is judged after the same cycle's issue. An insert into a full queue in a cycle that also issues evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_data_only_i | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash_i | input | 1 | Enable squash of late entries on a miss |
| cfg_check_on_push_i | input | 1 | Filter cache hits at insert instead of at issue |
| now_i | input | TW | Current time |
| miss_valid_i | input | 1 | Miss notification valid |
| miss_addr_i | input | AW | Miss physical address |
| miss_uncacheable_i | input | 1 | Miss is uncacheable |
| miss_ifetch_i | input | 1 | Miss is an instruction fetch |
| miss_time_i | input | TW | Time of the miss |
| cand_valid_i | input | 1 | Candidate valid |
| cand_ready_o | output | 1 | Candidate accepted this cycle |
| cand_addr_i | input | AW | Candidate physical address |
| cand_delay_i | input | TW | Candidate delay after the miss |
| cand_tag_hit_i | input | 1 | Cache lookup of candidate block hits |
| cand_mq_hit_i | input | 1 | Miss-queue lookup of candidate block hits |
| pf_valid_o | output | 1 | Head ready to issue |
| pf_ready_i | input | 1 | Request port takes the head |
| pf_addr_o | output | AW | Head block address |
| head_tag_hit_i | input | 1 | Cache lookup of `pf_addr_o` hits |
| pf_req_o | output | 1 | Prefetch request line to the port |
| pf_req_time_o | output | TW | Ready time of the last inserted entry |
| cnt_identified_o | output | CW | Candidates taken |
| cnt_buf_hit_o | output | CW | Candidates already queued |
| cnt_evicted_o | output | CW | Entries dropped by a full queue |
| cnt_miss_removed_o | output | CW | Entries removed by a matching miss |
| cnt_squashed_o | output | CW | Entries squashed by a miss |
| cnt_issued_o | output | CW | Entries issued |

## Verification
An issue and an insert can land in the same cycle. The interesting case is an insert arriving at a full queue whose ready head is being taken in that very cycle. The bench provokes this by filling all entries while time holds them back, then advancing time and offering a candidate together with `pf_ready_i`. It judges the result by three things: the issued count rises by one, the eviction count stays unchanged, and the draining order shows the new entry behind the three survivors.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    // Width of an index into a queue of the given depth (at least one bit).
    function automatic int unsigned pfq_idx_w(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Width of an occupancy count 0..depth.
    function automatic int unsigned pfq_cnt_w(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/pfq_cam.sv
// Parallel block-address comparator across all queue slots.
module pfq_cam #(
    parameter int DEPTH = 4,
    parameter int BW    = 26
) (
    input  logic [DEPTH-1:0]         vld_i,
    input  logic [DEPTH-1:0][BW-1:0] blk_i,
    input  logic [BW-1:0]            key_i,
    output logic [DEPTH-1:0]         hit_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign hit_o[i] = vld_i[i] && (blk_i[i] == key_i);
    end
endmodule

// File: rtl/pfq_compact.sv
// Packs the kept slots toward the head, preserving their order.
module pfq_compact
    import pfq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int BW    = 26,
    parameter int TW    = 16,
    localparam int IW   = pfq_idx_w(DEPTH),
    localparam int NW   = pfq_cnt_w(DEPTH)
) (
    input  logic [DEPTH-1:0]         keep_i,
    input  logic [DEPTH-1:0][BW-1:0] blk_i,
    input  logic [DEPTH-1:0][TW-1:0] tim_i,
    output logic [DEPTH-1:0]         vld_o,
    output logic [DEPTH-1:0][BW-1:0] blk_o,
    output logic [DEPTH-1:0][TW-1:0] tim_o,
    output logic [NW-1:0]            cnt_o
);
    logic [NW-1:0] slot;

    always_comb begin
        vld_o = '0;
        blk_o = '0;
        tim_o = '0;
        slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep_i[i]) begin
                vld_o[slot[IW-1:0]] = 1'b1;
                blk_o[slot[IW-1:0]] = blk_i[i];
                tim_o[slot[IW-1:0]] = tim_i[i];
                slot = slot + 1'b1;
            end
        end
        cnt_o = slot;
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int AW        = 32,
    parameter int BLK_BYTES = 64,
    parameter int TW        = 16,
    parameter int CW        = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_data_only_i,
    input  logic          cfg_serial_squash_i,
    input  logic          cfg_check_on_push_i,
    input  logic [TW-1:0] now_i,
    input  logic          miss_valid_i,
    input  logic [AW-1:0] miss_addr_i,
    input  logic          miss_uncacheable_i,
    input  logic          miss_ifetch_i,
    input  logic [TW-1:0] miss_time_i,
    input  logic          cand_valid_i,
    output logic          cand_ready_o,
    input  logic [AW-1:0] cand_addr_i,
    input  logic [TW-1:0] cand_delay_i,
    input  logic          cand_tag_hit_i,
    input  logic          cand_mq_hit_i,
    output logic          pf_valid_o,
    input  logic          pf_ready_i,
    output logic [AW-1:0] pf_addr_o,
    input  logic          head_tag_hit_i,
    output logic          pf_req_o,
    output logic [TW-1:0] pf_req_time_o,
    output logic [CW-1:0] cnt_identified_o,
    output logic [CW-1:0] cnt_buf_hit_o,
    output logic [CW-1:0] cnt_evicted_o,
    output logic [CW-1:0] cnt_miss_removed_o,
    output logic [CW-1:0] cnt_squashed_o,
    output logic [CW-1:0] cnt_issued_o
);
    localparam int OFFW = $clog2(BLK_BYTES);
    localparam int BW   = AW - OFFW;
    localparam int IW   = pfq_idx_w(DEPTH);
    localparam int NW   = pfq_cnt_w(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0][BW-1:0] blk;
        logic [DEPTH-1:0][TW-1:0] tim;
        logic [TW-1:0]            base;
        logic                     req;
        logic [TW-1:0]            req_time;
        logic [CW-1:0]            c_ident;
        logic [CW-1:0]            c_buf;
        logic [CW-1:0]            c_evict;
        logic [CW-1:0]            c_rm;
        logic [CW-1:0]            c_sq;
        logic [CW-1:0]            c_iss;
    } state_t;

    state_t st_d, st_q;

    logic [BW-1:0] miss_blk_d, cand_blk_d;
    logic          head_ready_d, head_drop_d, issue_d, pop_head_d;
    logic          miss_take_d, cand_take_d, filt_d, ins_d, evict_d;
    logic [TW-1:0] cand_time_d;
    logic [DEPTH-1:0] miss_hit_d, late_d, rm_d, sq_d, keep_d, dup_d;
    logic [DEPTH-1:0]         k_vld_d;
    logic [DEPTH-1:0][BW-1:0] k_blk_d;
    logic [DEPTH-1:0][TW-1:0] k_tim_d;
    logic [NW-1:0]            k_cnt_d;
    logic                     unused_low;

    assign miss_blk_d = miss_addr_i[AW-1:OFFW];
    assign cand_blk_d = cand_addr_i[AW-1:OFFW];
    assign unused_low = ^{miss_addr_i[OFFW-1:0], cand_addr_i[OFFW-1:0]};

    // Head eligibility and issue
    assign head_ready_d = st_q.vld[0] && (st_q.tim[0] <= now_i);
    assign head_drop_d  = head_ready_d && !cfg_check_on_push_i && head_tag_hit_i;
    assign pf_valid_o   = head_ready_d && !head_drop_d;
    assign issue_d      = pf_valid_o && pf_ready_i;
    assign pop_head_d   = head_drop_d || issue_d;

    // Miss and candidate acceptance
    assign miss_take_d  = miss_valid_i && !miss_uncacheable_i
                          && !(miss_ifetch_i && cfg_data_only_i);
    assign cand_ready_o = !miss_valid_i;
    assign cand_take_d  = cand_valid_i && cand_ready_o;
    assign cand_time_d  = st_q.base + cand_delay_i;

    pfq_cam #(.DEPTH(DEPTH), .BW(BW)) u_miss_cam (
        .vld_i (st_q.vld),
        .blk_i (st_q.blk),
        .key_i (miss_blk_d),
        .hit_o (miss_hit_d)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_late
        assign late_d[i] = st_q.vld[i] && (st_q.tim[i] >= miss_time_i);
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic gone;
            gone      = (i == 0) && pop_head_d;
            rm_d[i]   = miss_take_d && miss_hit_d[i] && !gone;
            sq_d[i]   = miss_take_d && cfg_serial_squash_i && late_d[i]
                        && !gone && !rm_d[i];
            keep_d[i] = st_q.vld[i] && !gone && !rm_d[i] && !sq_d[i];
        end
    end

    pfq_compact #(.DEPTH(DEPTH), .BW(BW), .TW(TW)) u_compact (
        .keep_i (keep_d),
        .blk_i  (st_q.blk),
        .tim_i  (st_q.tim),
        .vld_o  (k_vld_d),
        .blk_o  (k_blk_d),
        .tim_o  (k_tim_d),
        .cnt_o  (k_cnt_d)
    );

    pfq_cam #(.DEPTH(DEPTH), .BW(BW)) u_cand_cam (
        .vld_i (k_vld_d),
        .blk_i (k_blk_d),
        .key_i (cand_blk_d),
        .hit_o (dup_d)
    );

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        filt_d  = cand_take_d && !(cfg_check_on_push_i && cand_tag_hit_i)
                  && !cand_mq_hit_i;
        ins_d   = filt_d && !(|dup_d);
        evict_d = ins_d && (k_cnt_d == NW'(DEPTH));

        st_d.vld = k_vld_d;
        st_d.blk = k_blk_d;
        st_d.tim = k_tim_d;

        if (evict_d) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.vld[i] = k_vld_d[i+1];
                st_d.blk[i] = k_blk_d[i+1];
                st_d.tim[i] = k_tim_d[i+1];
            end
            st_d.vld[DEPTH-1] = 1'b1;
            st_d.blk[DEPTH-1] = cand_blk_d;
            st_d.tim[DEPTH-1] = cand_time_d;
        end else if (ins_d) begin
            st_d.vld[k_cnt_d[IW-1:0]] = 1'b1;
            st_d.blk[k_cnt_d[IW-1:0]] = cand_blk_d;
            st_d.tim[k_cnt_d[IW-1:0]] = cand_time_d;
        end

        if (miss_take_d) begin
            st_d.base = miss_time_i;
        end

        if (ins_d) begin
            st_d.req      = 1'b1;
            st_d.req_time = cand_time_d;
        end else if (k_cnt_d == '0) begin
            st_d.req = 1'b0;
        end

        st_d.c_ident = st_q.c_ident + CW'(cand_take_d);
        st_d.c_buf   = st_q.c_buf + CW'(filt_d && (|dup_d));
        st_d.c_evict = st_q.c_evict + CW'(evict_d);
        st_d.c_rm    = st_q.c_rm + CW'($countones(rm_d));
        st_d.c_sq    = st_q.c_sq + CW'($countones(sq_d));
        st_d.c_iss   = st_q.c_iss + CW'(issue_d);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_addr_o          = {st_q.blk[0], {OFFW{1'b0}}};
    assign pf_req_o           = st_q.req;
    assign pf_req_time_o      = st_q.req_time;
    assign cnt_identified_o   = st_q.c_ident;
    assign cnt_buf_hit_o      = st_q.c_buf;
    assign cnt_evicted_o      = st_q.c_evict;
    assign cnt_miss_removed_o = st_q.c_rm;
    assign cnt_squashed_o     = st_q.c_sq;
    assign cnt_issued_o       = st_q.c_iss;
endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
    parameter int CW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          miss_valid_i,
    input logic          miss_uncacheable_i,
    input logic          cand_valid_i,
    input logic          cand_ready_o,
    input logic          pf_valid_o,
    input logic          pf_ready_i,
    input logic          pf_req_o,
    input logic [CW-1:0] cnt_identified_o,
    input logic [CW-1:0] cnt_evicted_o,
    input logic [CW-1:0] cnt_miss_removed_o,
    input logic [CW-1:0] cnt_squashed_o,
    input logic [CW-1:0] cnt_issued_o
);
    // R10
    issue_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pf_valid_o && pf_ready_i) |=> (cnt_issued_o == $past(cnt_issued_o) + 1'b1));

    // R10
    issue_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pf_valid_o && pf_ready_i) |=> $stable(cnt_issued_o));

    // R8
    ident_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cand_valid_i && cand_ready_o) |=> (cnt_identified_o == $past(cnt_identified_o) + 1'b1));

    // R3
    uncached_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_valid_i && miss_uncacheable_i) |=> ($stable(cnt_miss_removed_o) && $stable(cnt_squashed_o)));

    // R11
    req_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pf_valid_o |-> pf_req_o);

    // R9
    evict_needs_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(cand_valid_i && cand_ready_o) |=> $stable(cnt_evicted_o));
endmodule

bind prefetch_queue prefetch_queue_chk #(.CW(CW)) u_chk (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .miss_valid_i       (miss_valid_i),
    .miss_uncacheable_i (miss_uncacheable_i),
    .cand_valid_i       (cand_valid_i),
    .cand_ready_o       (cand_ready_o),
    .pf_valid_o         (pf_valid_o),
    .pf_ready_i         (pf_ready_i),
    .pf_req_o           (pf_req_o),
    .cnt_identified_o   (cnt_identified_o),
    .cnt_evicted_o      (cnt_evicted_o),
    .cnt_miss_removed_o (cnt_miss_removed_o),
    .cnt_squashed_o     (cnt_squashed_o),
    .cnt_issued_o       (cnt_issued_o)
);

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_data_only = 1'b1, cfg_serial = 1'b0, cfg_push = 1'b1;
    logic [15:0] now = '0;
    logic        miss_valid = 1'b0, miss_unc = 1'b0, miss_if = 1'b0;
    logic [31:0] miss_addr = '0;
    logic [15:0] miss_time = '0;
    logic        cand_valid = 1'b0, cand_th = 1'b0, cand_mq = 1'b0;
    logic        cand_ready;
    logic [31:0] cand_addr = '0;
    logic [15:0] cand_delay = '0;
    logic        pf_valid, pf_req;
    logic        pf_ready = 1'b0;
    logic [31:0] pf_addr;
    logic [15:0] pf_req_time;
    logic        hh_en = 1'b0;
    logic [25:0] hh_blk = '0;
    logic        head_hit;
    logic [15:0] c_ident, c_buf, c_evict, c_rm, c_sq, c_iss;

    int n_cmp = 0;
    int n_bad = 0;
    int e_ident = 0, e_buf = 0, e_evict = 0, e_rm = 0, e_sq = 0, e_iss = 0;

    always #5 clk = ~clk;

    assign head_hit = hh_en && (pf_addr[31:6] == hh_blk);

    prefetch_queue u_dut (
        .clk_i (clk), .rst_ni (rst_n),
        .cfg_data_only_i (cfg_data_only), .cfg_serial_squash_i (cfg_serial),
        .cfg_check_on_push_i (cfg_push), .now_i (now),
        .miss_valid_i (miss_valid), .miss_addr_i (miss_addr),
        .miss_uncacheable_i (miss_unc), .miss_ifetch_i (miss_if), .miss_time_i (miss_time),
        .cand_valid_i (cand_valid), .cand_ready_o (cand_ready), .cand_addr_i (cand_addr),
        .cand_delay_i (cand_delay), .cand_tag_hit_i (cand_th), .cand_mq_hit_i (cand_mq),
        .pf_valid_o (pf_valid), .pf_ready_i (pf_ready), .pf_addr_o (pf_addr),
        .head_tag_hit_i (head_hit), .pf_req_o (pf_req), .pf_req_time_o (pf_req_time),
        .cnt_identified_o (c_ident), .cnt_buf_hit_o (c_buf), .cnt_evicted_o (c_evict),
        .cnt_miss_removed_o (c_rm), .cnt_squashed_o (c_sq), .cnt_issued_o (c_iss)
    );

    // Candidate vectors: kind 0 insert, 1 duplicate, 2 filtered, 3 insert with eviction
    typedef struct packed {
        logic [31:0] addr;
        logic [15:0] dly;
        logic        th;
        logic        mq;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{32'h0000_1000, 16'd1, 1'b0, 1'b0, 2'd0},
        '{32'h0000_1010, 16'd2, 1'b0, 1'b0, 2'd1},
        '{32'h0000_2000, 16'd2, 1'b1, 1'b0, 2'd2},
        '{32'h0000_3000, 16'd3, 1'b0, 1'b1, 2'd2},
        '{32'h0000_4000, 16'd3, 1'b0, 1'b0, 2'd0},
        '{32'h0000_5000, 16'd4, 1'b0, 1'b0, 2'd0},
        '{32'h0000_6000, 16'd5, 1'b0, 1'b0, 2'd0},
        '{32'h0000_7000, 16'd6, 1'b0, 1'b0, 2'd3}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_miss(input logic [31:0] a, input logic [15:0] t,
                           input logic unc, input logic ifetch);
        miss_valid = 1'b1; miss_addr = a; miss_time = t; miss_unc = unc; miss_if = ifetch;
        step();
        miss_valid = 1'b0; miss_unc = 1'b0; miss_if = 1'b0;
    endtask

    task automatic do_cand(input logic [31:0] a, input logic [15:0] d,
                           input logic th, input logic mq);
        cand_valid = 1'b1; cand_addr = a; cand_delay = d; cand_th = th; cand_mq = mq;
        step();
        cand_valid = 1'b0; cand_th = 1'b0; cand_mq = 1'b0;
        e_ident++;
    endtask

    task automatic check_counts(input string tag);
        chk({tag, " identified"}, 64'(c_ident), 64'(e_ident));
        chk({tag, " buf_hit"},    64'(c_buf),   64'(e_buf));
        chk({tag, " evicted"},    64'(c_evict), 64'(e_evict));
        chk({tag, " removed"},    64'(c_rm),    64'(e_rm));
        chk({tag, " squashed"},   64'(c_sq),    64'(e_sq));
        chk({tag, " issued"},     64'(c_iss),   64'(e_iss));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pf_valid", 64'(pf_valid), 64'd0);
        chk("R1 pf_req", 64'(pf_req), 64'd0);
        chk("R1 cand_ready", 64'(cand_ready), 64'd1);
        check_counts("R1");
        @(negedge clk);

        // Vector table: R2 R7 R8 R9 R11, time held at 0 so nothing issues (R6)
        do_miss(32'h0000_9000, 16'd100, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            do_cand(VEC[i].addr, VEC[i].dly, VEC[i].th, VEC[i].mq);
            if (VEC[i].kind == 2'd1) e_buf++;
            if (VEC[i].kind == 2'd3) e_evict++;
            chk("R8 identified", 64'(c_ident), 64'(e_ident));
            chk("R2/R7 buf_hit", 64'(c_buf), 64'(e_buf));
            chk("R9 evicted", 64'(c_evict), 64'(e_evict));
            if (VEC[i].kind == 2'd0 || VEC[i].kind == 2'd3)
                chk("R11 req_time", 64'(pf_req_time), 64'(16'd100 + VEC[i].dly));
            chk("R6 not ready", 64'(pf_valid), 64'd0);
        end

        // Drain in FIFO order: R10 R9 (head 0x1000 was evicted)
        now = 16'd200; pf_ready = 1'b1;
        #1;
        for (int k = 0; k < 4; k++) begin
            chk("R10 valid", 64'(pf_valid), 64'd1);
            chk("R10/R9 order", 64'(pf_addr), 64'(32'h4000 + 32'h1000 * k));
            step();
            e_iss++;
        end
        pf_ready = 1'b0;
        #1;
        chk("R11 req low after drain", 64'(pf_req), 64'd0);
        check_counts("R10 drain");

        // R6 ready-time gate
        now = 16'd14;
        do_miss(32'h0000_A000, 16'd10, 1'b0, 1'b0);
        do_cand(32'h0000_B000, 16'd5, 1'b0, 1'b0);
        #1;
        chk("R6 early", 64'(pf_valid), 64'd0);
        now = 16'd15;
        #1;
        chk("R6 on time", 64'(pf_valid), 64'd1);
        chk("R6 addr", 64'(pf_addr), 64'(32'h0000_B000));
        @(negedge clk);

        // R3 ignored misses
        do_miss(32'h0000_B000, 16'd0, 1'b1, 1'b0);
        chk("R3 uncacheable removed", 64'(c_rm), 64'(e_rm));
        chk("R3 uncacheable keeps head", 64'(pf_valid), 64'd1);
        do_miss(32'h0000_B000, 16'd0, 1'b0, 1'b1);
        chk("R3 ifetch data-only removed", 64'(c_rm), 64'(e_rm));
        chk("R3 ifetch data-only keeps head", 64'(pf_valid), 64'd1);

        // R4 accepted ifetch miss (data-only off) removes same block, R11 req drops
        cfg_data_only = 1'b0;
        do_miss(32'h0000_B020, 16'd0, 1'b0, 1'b1);
        e_rm++;
        chk("R4 removed", 64'(c_rm), 64'(e_rm));
        chk("R4 head gone", 64'(pf_valid), 64'd0);
        chk("R11 req low after removal", 64'(pf_req), 64'd0);

        // R5 squash off then on
        do_miss(32'h0000_C000, 16'd100, 1'b0, 1'b0);
        do_cand(32'h0000_C100, 16'd5, 1'b0, 1'b0);
        do_cand(32'h0000_C200, 16'd10, 1'b0, 1'b0);
        do_cand(32'h0000_C300, 16'd20, 1'b0, 1'b0);
        do_miss(32'h0000_E000, 16'd100, 1'b0, 1'b0);
        chk("R5 squash off", 64'(c_sq), 64'(e_sq));
        cfg_serial = 1'b1;
        do_miss(32'h0000_D000, 16'd110, 1'b0, 1'b0);
        e_sq += 2;
        chk("R5 squash count", 64'(c_sq), 64'(e_sq));
        now = 16'd200; pf_ready = 1'b1;
        #1;
        chk("R5 survivor", 64'(pf_addr), 64'(32'h0000_C100));
        step();
        e_iss++;
        pf_ready = 1'b0;
        #1;
        chk("R5 nothing left", 64'(pf_valid), 64'd0);
        chk("R11 req low after squash", 64'(pf_req), 64'd0);
        cfg_serial = 1'b0;
        @(negedge clk);

        // R10 discard at issue when check-on-push is clear; R7 tag hit ignored at push
        cfg_push = 1'b0; hh_en = 1'b1; hh_blk = 26'(32'h0000_5500 >> 6);
        do_miss(32'h0000_F000, 16'd0, 1'b0, 1'b0);
        do_cand(32'h0000_5500, 16'd0, 1'b1, 1'b0);
        #1;
        chk("R7 push-check off inserts", 64'(pf_req), 64'd1);
        chk("R10 hit head not offered", 64'(pf_valid), 64'd0);
        @(negedge clk);
        step();
        chk("R10 discard not issued", 64'(c_iss), 64'(e_iss));
        chk("R11 req low after discard", 64'(pf_req), 64'd0);
        hh_en = 1'b0; cfg_push = 1'b1;

        // R13 issue and insert in the same cycle at full occupancy
        now = 16'd0;
        do_miss(32'h0001_0000, 16'd50, 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++)
            do_cand(32'h0001_0000 + 32'h1000 * k, 16'd0, 1'b0, 1'b0);
        now = 16'd100; pf_ready = 1'b1;
        cand_valid = 1'b1; cand_addr = 32'h0001_5000; cand_delay = 16'd1;
        step();
        cand_valid = 1'b0;
        e_ident++; e_iss++;
        #1;
        chk("R13 issued", 64'(c_iss), 64'(e_iss));
        chk("R13 no eviction", 64'(c_evict), 64'(e_evict));
        for (int k = 2; k <= 5; k++) begin
            chk("R13 order", 64'(pf_addr), 64'(32'h0001_0000 + 32'h1000 * k));
            step();
            e_iss++;
        end
        pf_ready = 1'b0;

        // R12 miss priority over candidates
        miss_valid = 1'b1; miss_unc = 1'b1; miss_addr = 32'h0002_0000;
        cand_valid = 1'b1; cand_addr = 32'h0003_0000; cand_delay = 16'd0;
        #1;
        chk("R12 cand_ready low", 64'(cand_ready), 64'd0);
        step();
        miss_valid = 1'b0; miss_unc = 1'b0; cand_valid = 1'b0;
        #1;
        chk("R12 not taken", 64'(c_ident), 64'(e_ident));
        chk("R12 req stays low", 64'(pf_req), 64'd0);
        check_counts("final");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule